// File: doc/BRIEF.md
# Phase-Accumulator Tone and Density Generator

This block produces four digital output pins from a shared tick enable. Two tone channels each keep a 16-bit phase accumulator. On every tick they add a programmable increment to it and drive a square wave from its most significant bit. The output frequency is therefore tick_rate × increment / 65536, linear in the increment.

Two density channels each keep an 8-bit accumulator. On every tick they add a programmable duty value to it. Their pin is high for exactly those tick periods in which the addition carried out of the top bit. The result is a pulse-density stream whose average high fraction is duty/256, ready for a simple RC filter.

Software-side logic loads the four programmable values through a single write port. Tick generation and any bus bridging sit outside the block.

Top module: `pdg_top`

## Requirements
- R1: While `rst` is high at a clock edge, every accumulator and every output clears to 0, each tone increment becomes 1 (only bit 0 set), and each duty value becomes 0.
- R2: On a clock edge with `tick` high, each tone accumulator becomes (accumulator + increment) modulo 65536, with the low-byte carry propagating into the high byte.
- R3: After a tick, `tone_out[i]` equals bit 15 of tone accumulator i after that tick's addition; the pin is registered.
- R4: On a clock edge with `tick` high, each duty accumulator becomes (accumulator + duty) modulo 256.
- R5: After a tick, `dens_out[i]` is 1 exactly when that tick's duty addition carried out of bit 7, and 0 otherwise.
- R6: A duty value of 0 never gives a high tick. A duty value of 255 gives 255 high ticks in any 256 consecutive ticks. In general, any 256 consecutive ticks hold exactly `duty` high ticks.
- R7: A write (`wr_en` high) decodes `wr_sel` as follows. Code 0 loads the tone 0 increment and code 1 loads the tone 1 increment, each from `wr_data[15:0]`. Code 2 loads the duty 0 value and code 3 loads the duty 1 value, each from `wr_data[7:0]`; for these codes `wr_data[15:8]` is ignored.
- R8: A write leaves every accumulator unchanged, so phase is continuous. When a write and a tick fall on the same edge, that tick's addition uses the value held before the write.
- R9: On edges with `tick` low, no accumulator and no output changes.
- R10: With the reset-default increment, a tone output stays low for the first 32767 ticks after reset and goes high on tick 32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable that advances all accumulators |
| wr_en | input | 1 | Write strobe for a programmable value |
| wr_sel | input | 2 | Target select: 0/1 tone increments, 2/3 duty values |
| wr_data | input | 16 | Write data (duty writes use bits 7:0) |
| tone_out | output | 2 | Square-wave pins, one per tone channel |
| dens_out | output | 2 | Pulse-density pins, one per duty channel |

## Verification
Accumulator state is never visible directly, so a corrupted tone accumulator or increment only shows as an MSB transition on the wrong tick. With large increments that appears within a few ticks. With the default increment it can hide for up to 32768 ticks, which is why the bench runs the full half-period after reset. A wrong duty accumulator, or a lost or extra carry, shows up as a mismatched pin within at most 256 ticks and as a wrong high-tick count over any 256-tick window. Per-tick comparison against an arithmetic model catches phase discontinuity after writes, and use of the new value on a coincident write, on the next tick that crosses a boundary.

// File: rtl/pdg_pkg.sv
package pdg_pkg;

    // Write target codes; tone codes precede duty codes.
    typedef enum logic [1:0] {
        SEL_TONE0 = 2'd0,
        SEL_TONE1 = 2'd1,
        SEL_DUTY0 = 2'd2,
        SEL_DUTY1 = 2'd3
    } wsel_e;

    localparam int TONE_W_DEF = 16;
    localparam int DUTY_W_DEF = 8;
    localparam int N_TONE_DEF = 2;
    localparam int N_DUTY_DEF = 2;

    // Split-width add: low half carry feeds the high half.
    function automatic logic [TONE_W_DEF-1:0] split_add16(
        input logic [TONE_W_DEF-1:0] a,
        input logic [TONE_W_DEF-1:0] b
    );
        logic [TONE_W_DEF/2:0]   lo;
        logic [TONE_W_DEF/2-1:0] hi;
        lo = {1'b0, a[TONE_W_DEF/2-1:0]} + {1'b0, b[TONE_W_DEF/2-1:0]};
        hi = a[TONE_W_DEF-1:TONE_W_DEF/2] + b[TONE_W_DEF-1:TONE_W_DEF/2]
             + {{(TONE_W_DEF/2-1){1'b0}}, lo[TONE_W_DEF/2]};
        return {hi, lo[TONE_W_DEF/2-1:0]};
    endfunction

endpackage

// File: rtl/pdg_cfg.sv
module pdg_cfg #(
    parameter int TONE_W = 16,
    parameter int DUTY_W = 8,
    parameter int N_TONE = 2,
    parameter int N_DUTY = 2,
    localparam int SEL_W = $clog2(N_TONE + N_DUTY)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [TONE_W-1:0]              wr_data,
    output logic [N_TONE-1:0][TONE_W-1:0]  inc,
    output logic [N_DUTY-1:0][DUTY_W-1:0]  duty
);
    localparam logic [TONE_W-1:0] INC_RST = TONE_W'(1);

    for (genvar k = 0; k < N_TONE; k++) begin : g_inc
        always_ff @(posedge clk) begin
            if (rst) begin
                inc[k] <= INC_RST;
            end else if (wr_en && wr_sel == SEL_W'(k)) begin
                inc[k] <= wr_data;
            end
        end
    end

    for (genvar k = 0; k < N_DUTY; k++) begin : g_duty
        always_ff @(posedge clk) begin
            if (rst) begin
                duty[k] <= '0;
            end else if (wr_en && wr_sel == SEL_W'(N_TONE + k)) begin
                duty[k] <= wr_data[DUTY_W-1:0];
            end
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(inc) && $stable(duty))) else $error("cfg changed without write"); // R7

endmodule

// File: rtl/pdg_tone_ch.sv
module pdg_tone_ch
    import pdg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] inc,
    output logic         sq_out
);
    logic [W-1:0] acc;
    logic [W-1:0] acc_nx;

    // Byte-split add when the width matches the package helper.
    if (W == TONE_W_DEF) begin : g_split
        always_comb acc_nx = split_add16(acc, inc);
    end else begin : g_plain
        always_comb acc_nx = acc + inc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            sq_out <= 1'b0;
        end else if (tick) begin
            acc    <= acc_nx;
            sq_out <= acc_nx[W-1];
        end
    end

    AST_TONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(acc) && $stable(sq_out))) else $error("tone moved without tick"); // R9
    AST_TONE_MSB: assert property (@(posedge clk) disable iff (rst)
        tick |=> (sq_out == acc[W-1])) else $error("tone pin not accumulator msb"); // R3

endmodule

// File: rtl/pdg_dens_ch.sv
module pdg_dens_ch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] duty,
    output logic         pd_out
);
    logic [W-1:0] acc;
    logic [W:0]   sum;

    always_comb sum = {1'b0, acc} + {1'b0, duty};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            pd_out <= 1'b0;
        end else if (tick) begin
            acc    <= sum[W-1:0];
            pd_out <= sum[W];
        end
    end

    AST_DUTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick && duty == '0) |=> !pd_out) else $error("duty 0 produced high tick"); // R6
    AST_DUTY_FULL: assert property (@(posedge clk) disable iff (rst)
        (tick && duty == '1 && acc != '0) |=> pd_out) else $error("full duty missed carry"); // R6
    AST_DUTY_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(acc) && $stable(pd_out))) else $error("density moved without tick"); // R9

endmodule

// File: rtl/pdg_top.sv
module pdg_top
    import pdg_pkg::*;
#(
    parameter int TONE_W = TONE_W_DEF,
    parameter int DUTY_W = DUTY_W_DEF,
    parameter int N_TONE = N_TONE_DEF,
    parameter int N_DUTY = N_DUTY_DEF,
    localparam int SEL_W = $clog2(N_TONE + N_DUTY)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [TONE_W-1:0] wr_data,
    output logic [N_TONE-1:0] tone_out,
    output logic [N_DUTY-1:0] dens_out
);
    logic [N_TONE-1:0][TONE_W-1:0] inc;
    logic [N_DUTY-1:0][DUTY_W-1:0] duty;

    pdg_cfg #(
        .TONE_W (TONE_W),
        .DUTY_W (DUTY_W),
        .N_TONE (N_TONE),
        .N_DUTY (N_DUTY)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .inc     (inc),
        .duty    (duty)
    );

    for (genvar i = 0; i < N_TONE; i++) begin : g_tone
        pdg_tone_ch #(.W(TONE_W)) u_tone (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .inc    (inc[i]),
            .sq_out (tone_out[i])
        );
    end

    for (genvar i = 0; i < N_DUTY; i++) begin : g_dens
        pdg_dens_ch #(.W(DUTY_W)) u_dens (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .duty   (duty[i]),
            .pd_out (dens_out[i])
        );
    end

endmodule

// File: tb/pdg_top_bench.sv
module pdg_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  tone_out;
    logic [1:0]  dens_out;

    int vectors = 0;
    int miscompares = 0;

    int m_tacc [2];
    int m_inc  [2];
    int m_dacc [2];
    int m_duty [2];
    logic [1:0] e_tone;
    logic [1:0] e_dens;
    int hi_cnt [2];

    always #10 clk = ~clk;

    pdg_top u_pdg_top (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .tone_out (tone_out),
        .dens_out (dens_out)
    );

    task automatic check_int(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge.
    task automatic step(input logic t, input logic we, input logic [1:0] sel,
                        input logic [15:0] d, input string req);
        tick = t; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        if (t) begin
            for (int i = 0; i < 2; i++) begin
                int s;
                m_tacc[i] = (m_tacc[i] + m_inc[i]) % 65536;
                e_tone[i] = m_tacc[i][15];
                s = m_dacc[i] + m_duty[i];
                e_dens[i] = (s > 255);
                m_dacc[i] = s % 256;
            end
        end
        if (we) begin
            if (sel < 2) m_inc[sel] = int'(d);
            else         m_duty[sel-2] = int'(d[7:0]);
        end
        @(negedge clk);
        check_int({req, " tone_out"}, int'(tone_out), int'(e_tone));
        check_int({req, " dens_out"}, int'(dens_out), int'(e_dens));
        for (int i = 0; i < 2; i++) if (t && dens_out[i]) hi_cnt[i]++;
    endtask

    task automatic run(input int n, input string req);
        for (int k = 0; k < n; k++) step(1'b1, 1'b0, 2'd0, 16'd0, req);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d, input string req);
        step(1'b0, 1'b1, sel, d, req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_tacc[i] = 0; m_inc[i] = 1; m_dacc[i] = 0; m_duty[i] = 0;
        end
        e_tone = '0; e_dens = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the pins
        check_int("R1 reset tone_out", int'(tone_out), 0);
        check_int("R1 reset dens_out", int'(dens_out), 0);

        // R10: default increment walks 32767 ticks low, then high
        run(32767, "R10 default increment");
        check_int("R10 tone low before half period", int'(tone_out), 0);
        check_int("R6 duty zero stays low", int'(dens_out), 0);
        run(1, "R10 half period");
        check_int("R10 tone high at tick 32768", int'(tone_out), 3);

        // R9: idle cycles change nothing
        for (int k = 0; k < 20; k++) step(1'b0, 1'b0, 2'd0, 16'd0, "R9 no tick");

        // R7: duty writes ignore upper data bits; R6 full and minimum duty
        wr(2'd2, 16'hA5FF, "R7 duty0 write");
        wr(2'd3, 16'hFF01, "R7 duty1 write");
        hi_cnt[0] = 0; hi_cnt[1] = 0;
        run(256, "R5 density stream");
        check_int("R6 duty 255 count", hi_cnt[0], 255);
        check_int("R7 duty1 low byte only count", hi_cnt[1], 1);

        // R6/R4: sweep duty values, count over 256 ticks each
        for (int d = 0; d < 256; d += 37) begin
            wr(2'd2, 16'(d), "R7 duty0 sweep write");
            wr(2'd3, 16'(255 - d), "R7 duty1 sweep write");
            hi_cnt[0] = 0; hi_cnt[1] = 0;
            run(256, "R4 duty sweep");
            check_int("R6 duty0 density count", hi_cnt[0], d);
            check_int("R6 duty1 density count", hi_cnt[1], 255 - d);
        end

        // R2/R3: several tone increments, per-tick model compare
        wr(2'd0, 16'h1234, "R7 tone0 write");
        wr(2'd1, 16'hFFFF, "R7 tone1 write");
        run(1500, "R2 tone add");
        wr(2'd0, 16'h8000, "R7 tone0 write");
        wr(2'd1, 16'h00FF, "R7 tone1 write");
        run(1500, "R3 tone msb");

        // R8: writes coincide with ticks; old value applies, phase continues
        for (int k = 0; k < 64; k++) begin
            step(1'b1, 1'b1, 2'(k % 4), 16'(k * 16'h0731 + 16'h00C3), "R8 coincident write");
            run(3, "R8 phase continuity");
        end
        // R9 again with writes pending but no tick
        for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 2'(k % 4), 16'(k * 16'h1111), "R9 write without tick");
        run(600, "R8 continuity after writes");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule